// File: doc/BRIEF.md
# Oversampling serial receiver with two-slot queue

This block receives characters from an asynchronous serial line. It brings the line into the clock domain through a synchronizer. It finds the start of each character and times every bit with a programmable divisor that sets the oversample tick rate. The data bits are assembled least-significant first, either 8 or 9 of them per character. Each completed character is written into a small queue along with two status bits: its ninth bit and a flag for a missing stop bit. The outputs always show the oldest unread character and its two status bits. Software reads the character, then pulses a read strobe to discard it.

A multi-drop mode accepts only characters whose ninth bit is set. Slave devices use this to listen for address characters and skip data meant for other devices. When a character completes while the queue is full, the block sets a sticky overrun flag and drops the character. While the flag is set, reception is frozen. Clearing the receive enable clears the flag. Clearing the port enable clears the flag and also empties the queue.

Top module: `arx_top`

## Requirements
- R1: After reset, and one cycle after `port_en` goes low, the queue is empty and `rd_data`, `rd_bit9`, `rd_ferr`, `ovr_err` and `rx_pend` all read 0.
- R2: A character is a low start bit, then data bits least-significant first, then a stop bit. Each bit lasts 16·(`div_val`+1) clock cycles. With `nine_en` low, 8 data bits are received and `rd_bit9` reads 0.
- R3: With `nine_en` high, 9 data bits are received. The last of them is the most significant and appears on `rd_bit9`, while the low 8 bits appear on `rd_data`.
- R4: While `addr_en` and `nine_en` are both high, a character whose ninth bit is 0 is dropped without a trace. It does not enter the queue, does not raise `rx_pend` and does not count toward overrun.
- R5: Every queue slot holds its own stop-bit error flag. A character whose stop bit samples low sets the flag. `rd_ferr` shows the flag of the oldest slot, and a pop moves it to the next slot.
- R6: A stop-bit error does not block later characters, and it creates no pending condition beyond the character it belongs to.
- R7: `rx_pend` is 1 exactly when `port_en` is high and the queue holds at least one character. The queue is first-in first-out.
- R8: The queue holds two characters. When a third character completes while the queue is full and nothing is popped in that cycle, `ovr_err` goes to 1, that character is lost, and the stored characters remain readable.
- R9: While `ovr_err` is 1, no character is stored, even after a pop makes room. Only `cont_en` low or `port_en` low clears `ovr_err`. `cont_en` low leaves the stored characters and their status intact.
- R10: A low pulse on `rx_in` that has ended before the middle of the start bit does not start a character.
- R11: A `rd_pop` pulse while the queue is empty has no effect. The status outputs can be observed without changing anything.
- R12: A character completes in the same cycle that its stop bit is judged. If a pop happens in that same cycle with the queue full, the pop is applied first, the character is stored, and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Serial port enable; low clears the whole receiver |
| cont_en | input | 1 | Continuous receive enable; low idles the receiver and clears overrun |
| nine_en | input | 1 | 9 data bits per character when high |
| addr_en | input | 1 | Address filtering (needs `nine_en`) |
| div_val | input | DIV_W (12) | Tick divisor; one oversample tick every `div_val`+1 cycles |
| rx_in | input | 1 | Serial line, idle high |
| rd_pop | input | 1 | One-cycle strobe that discards the oldest character |
| rd_data | output | DATA_W (8) | Low data bits of the oldest character |
| rd_bit9 | output | 1 | Ninth bit of the oldest character |
| rd_ferr | output | 1 | Stop-bit error flag of the oldest character |
| ovr_err | output | 1 | Sticky overrun flag |
| rx_pend | output | 1 | At least one unread character |

## Verification
The hardest case to reach is R12: a pop in the exact cycle that a third character completes into a full queue. The bench first runs a calibration pass with the queue empty. It counts cycles from the start bit to the rise of `rx_pend`, which fixes the completion cycle relative to the frame. It then replays the same frame with the queue full and pulses the strobe in that cycle. A second replay pulses one cycle later, where an overrun is expected. The 8-bit character space is swept in full at the fastest divisor, and the 9-bit mode with a slower divisor.

// File: rtl/arx_pkg.sv
package arx_pkg;

   // oversample ticks per bit
   localparam int OVS = 16;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } rx_state_e;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction

endpackage

// File: rtl/arx_baud.sv
module arx_baud #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run)
         cnt_q <= '0;
      else if (cnt_q == '0)
         cnt_q <= div;
      else
         cnt_q <= cnt_q - 1'b1;
   end

   assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/arx_frame.sv
module arx_frame
   import arx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit MAJORITY    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic              rx_in,
   input  logic              nine_en,
   output logic              done,
   output logic [DATA_W-1:0] dout,
   output logic              d9,
   output logic              ferr
);

   localparam int TCK_W = $clog2(OVS);
   localparam int BIT_W = $clog2(DATA_W + 1);
   localparam logic [TCK_W-1:0] C_MID = TCK_W'(OVS / 2);
   localparam logic [TCK_W-1:0] C_S1  = C_MID - 1'b1;
   localparam logic [TCK_W-1:0] C_S2  = C_MID + 1'b1;
   localparam logic [TCK_W-1:0] C_END = TCK_W'(OVS - 1);

   // input synchronizer, idle level high
   logic [SYNC_STAGES-1:0] sy_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sy_q <= '1;
      else
         sy_q <= {sy_q[SYNC_STAGES-2:0], rx_in};
   end
   logic rx_s;
   assign rx_s = sy_q[SYNC_STAGES-1];

   rx_state_e          st_q;
   logic [TCK_W-1:0]   cnt_q;
   logic [BIT_W-1:0]   bitn_q;
   logic [DATA_W:0]    sh_q;
   logic               prev_q, s1_q, s2_q, nine_q;
   logic               vote;
   logic [BIT_W-1:0]   last_idx;

   generate
      if (MAJORITY) begin : g_vote3
         assign vote = maj3(s1_q, s2_q, rx_s);
      end else begin : g_vote1
         assign vote = s2_q;
      end
   endgenerate

   assign last_idx = nine_q ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         prev_q <= 1'b1;
      else
         prev_q <= rx_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         bitn_q <= '0;
         sh_q   <= '0;
         s1_q   <= 1'b1;
         s2_q   <= 1'b1;
         nine_q <= 1'b0;
      end else if (!run) begin
         st_q <= ST_IDLE;
      end else if (st_q == ST_IDLE) begin
         if (prev_q && !rx_s) begin
            st_q   <= ST_START;
            cnt_q  <= '0;
            nine_q <= nine_en;
         end
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == C_S1) s1_q <= rx_s;
         if (cnt_q == C_MID) s2_q <= rx_s;
         case (st_q)
            ST_START: begin
               if (cnt_q == C_MID && rx_s)
                  st_q <= ST_IDLE;
               else if (cnt_q == C_END) begin
                  st_q   <= ST_DATA;
                  bitn_q <= '0;
               end
            end
            ST_DATA: begin
               if (cnt_q == C_S2)
                  sh_q <= {vote, sh_q[DATA_W:1]};
               if (cnt_q == C_END) begin
                  if (bitn_q == last_idx)
                     st_q <= ST_STOP;
                  else
                     bitn_q <= bitn_q + 1'b1;
               end
            end
            ST_STOP: begin
               if (cnt_q == C_S2)
                  st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign done = run && tick && (st_q == ST_STOP) && (cnt_q == C_S2);
   assign dout = nine_q ? sh_q[DATA_W-1:0] : sh_q[DATA_W:1];
   assign d9   = nine_q & sh_q[DATA_W];
   assign ferr = ~vote;

endmodule

// File: rtl/arx_queue.sv
module arx_queue #(
   parameter int WIDTH = 10,
   parameter int DEPTH = 2,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             ovr_clr,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rdata,
   output logic [LVL_W-1:0] level,
   output logic             ovr
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0] wr_q, rd_q;
   logic [LVL_W-1:0] lvl_q;
   logic             ovr_q;
   logic             pop_ok, full, wr, ovr_set;

   function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign pop_ok  = pop && (lvl_q != '0);
   assign full    = (lvl_q == LVL_W'(DEPTH));
   assign wr      = push && !ovr_q && (!full || pop_ok);
   assign ovr_set = push && !ovr_q && full && !pop_ok;

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (wr && wr_q == PTR_W'(i))
            mem_q[i] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         lvl_q <= '0;
         ovr_q <= 1'b0;
      end else if (clr) begin
         wr_q  <= '0;
         rd_q  <= '0;
         lvl_q <= '0;
         ovr_q <= 1'b0;
      end else begin
         if (wr)     wr_q <= nxt(wr_q);
         if (pop_ok) rd_q <= nxt(rd_q);
         case ({wr, pop_ok})
            2'b10:   lvl_q <= lvl_q + 1'b1;
            2'b01:   lvl_q <= lvl_q - 1'b1;
            default: lvl_q <= lvl_q;
         endcase
         if (ovr_clr)
            ovr_q <= 1'b0;
         else if (ovr_set)
            ovr_q <= 1'b1;
      end
   end

   assign rdata = (lvl_q != '0) ? mem_q[rd_q] : '0;
   assign level = lvl_q;
   assign ovr   = ovr_q;

endmodule

// File: rtl/arx_top.sv
module arx_top #(
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 2,
   parameter int DIV_W       = 12,
   parameter int SYNC_STAGES = 2,
   parameter bit MAJORITY    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              cont_en,
   input  logic              nine_en,
   input  logic              addr_en,
   input  logic [DIV_W-1:0]  div_val,
   input  logic              rx_in,
   input  logic              rd_pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_bit9,
   output logic              rd_ferr,
   output logic              ovr_err,
   output logic              rx_pend
);

   localparam int ENT_W = DATA_W + 2;
   localparam int LVL_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("arx_top: DEPTH must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("arx_top: SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 5) begin : g_bad_width
         $error("arx_top: DATA_W must be at least 5");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("arx_top: DIV_W must be at least 1");
      end
   endgenerate

   logic              run, tick;
   logic              frm_done, frm_d9, frm_ferr;
   logic [DATA_W-1:0] frm_data;
   logic              q_push;
   logic [ENT_W-1:0]  q_top;
   logic [LVL_W-1:0]  q_level;

   assign run = port_en && cont_en;

   arx_baud #(.DIV_W(DIV_W)) u_baud (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .div  (div_val),
      .tick (tick)
   );

   arx_frame #(
      .DATA_W     (DATA_W),
      .SYNC_STAGES(SYNC_STAGES),
      .MAJORITY   (MAJORITY)
   ) u_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .tick   (tick),
      .rx_in  (rx_in),
      .nine_en(nine_en),
      .done   (frm_done),
      .dout   (frm_data),
      .d9     (frm_d9),
      .ferr   (frm_ferr)
   );

   // multi-drop filter: with address mode active only ninth-bit-set characters pass
   assign q_push = frm_done && !(addr_en && nine_en && !frm_d9);

   arx_queue #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_queue (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (!port_en),
      .ovr_clr(!cont_en),
      .push   (q_push),
      .pop    (rd_pop),
      .wdata  ({frm_ferr, frm_d9, frm_data}),
      .rdata  (q_top),
      .level  (q_level),
      .ovr    (ovr_err)
   );

   assign rd_data = q_top[DATA_W-1:0];
   assign rd_bit9 = q_top[DATA_W];
   assign rd_ferr = q_top[DATA_W+1];
   assign rx_pend = port_en && (q_level != '0);

endmodule

// File: rtl/arx_checker.sv
module arx_checker #(
   parameter int DEPTH = 2,
   localparam int LVL_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             port_en,
   input logic             cont_en,
   input logic             nine_en,
   input logic             addr_en,
   input logic             rd_pop,
   input logic             ovr_err,
   input logic             rx_pend,
   input logic [LVL_W-1:0] q_level,
   input logic             q_push,
   input logic             frm_d9
);

   localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

   // R1
   port_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> (!rx_pend && q_level == '0 && !ovr_err));

   // R4
   addr_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_push && addr_en && nine_en) |-> frm_d9);

   // R8
   ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_err) |-> $past(q_level == FULL && q_push && !rd_pop && port_en && cont_en));

   // R9
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_err && port_en && cont_en) |=> ovr_err);

   // R9
   ovr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cont_en |=> !ovr_err);

   // R9
   ovr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_err && port_en && !rd_pop) |=> (q_level == $past(q_level)));

   // R11
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_level == '0 && !q_push && port_en) |=> q_level == '0);

   // R12
   tie_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_push && rd_pop && q_level == FULL && !ovr_err && port_en && cont_en)
      |=> (!ovr_err && q_level == FULL));

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_level <= FULL);

endmodule

bind arx_top arx_checker #(.DEPTH(DEPTH)) u_arx_checker (
   .clk    (clk),
   .rst_n  (rst_n),
   .port_en(port_en),
   .cont_en(cont_en),
   .nine_en(nine_en),
   .addr_en(addr_en),
   .rd_pop (rd_pop),
   .ovr_err(ovr_err),
   .rx_pend(rx_pend),
   .q_level(q_level),
   .q_push (q_push),
   .frm_d9 (frm_d9)
);

// File: tb/arx_top_bench.sv
module arx_top_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        port_en = 1'b0, cont_en = 1'b0, nine_en = 1'b0, addr_en = 1'b0;
   logic [11:0] div_val = '0;
   logic        rx_in = 1'b1;
   logic        rd_pop = 1'b0;
   logic [7:0]  rd_data;
   logic        rd_bit9, rd_ferr, ovr_err, rx_pend;

   int checks = 0;
   int errs   = 0;
   bit done_f = 1'b0;

   always #10 clk = ~clk;

   arx_top u_arx_top (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .cont_en(cont_en),
      .nine_en(nine_en), .addr_en(addr_en), .div_val(div_val), .rx_in(rx_in),
      .rd_pop(rd_pop), .rd_data(rd_data), .rd_bit9(rd_bit9), .rd_ferr(rd_ferr),
      .ovr_err(ovr_err), .rx_pend(rx_pend)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive one frame; bit period bc cycles; optional pop at negedge index pop_at
   task automatic send(input logic [8:0] v, input int nb, input logic stopv,
                       input int bc, input int pop_at, output int pend_at);
      int total;
      total   = (nb + 3) * bc;
      pend_at = -1;
      for (int i = 0; i < total; i++) begin
         int b;
         @(negedge clk);
         if (pend_at < 0 && rx_pend) pend_at = i;
         rd_pop = (i == pop_at);
         b = i / bc;
         if (b == 0)            rx_in = 1'b0;
         else if (b <= nb)      rx_in = v[b-1];
         else if (b == nb + 1)  rx_in = stopv;
         else                   rx_in = 1'b1;
      end
      @(negedge clk);
      rd_pop = 1'b0;
      rx_in  = 1'b1;
   endtask

   task automatic tx(input logic [8:0] v, input int nb, input logic stopv, input int bc);
      int dummy;
      send(v, nb, stopv, bc, -1, dummy);
   endtask

   task automatic pop1();
      @(negedge clk) rd_pop = 1'b1;
      @(negedge clk) rd_pop = 1'b0;
   endtask

   task automatic read_top(input int d, input bit b9, input bit fe, input string req);
      @(negedge clk);
      chk(rx_pend == 1'b1, req, rx_pend, 1);
      chk(rd_data == d[7:0], req, rd_data, d);
      chk(rd_bit9 == b9, req, rd_bit9, b9);
      chk(rd_ferr == fe, req, rd_ferr, fe);
      pop1();
   endtask

   task automatic port_cycle();
      @(negedge clk) port_en = 1'b0;
      @(negedge clk) port_en = 1'b1;
   endtask

   initial begin
      int p, pa;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(rd_data == 8'h00, "R1 data", rd_data, 0);
      chk({rd_bit9, rd_ferr, ovr_err, rx_pend} == 4'b0, "R1 flags",
          {rd_bit9, rd_ferr, ovr_err, rx_pend}, 0);

      port_en = 1'b1; cont_en = 1'b1; div_val = 12'd0;
      // R11 pop on empty
      pop1();
      @(negedge clk);
      chk(rx_pend == 1'b0 && ovr_err == 1'b0, "R11 empty pop", {rx_pend, ovr_err}, 0);
      tx(9'h0C3, 8, 1'b1, 16);
      read_top(8'hC3, 0, 0, "R11 after empty pop");

      // R2 exhaustive 8-bit sweep at fastest divisor
      for (int v = 0; v < 256; v++) begin
         tx(9'(v), 8, 1'b1, 16);
         read_top(v, 0, 0, "R2 sweep");
      end
      @(negedge clk);
      chk(rx_pend == 1'b0, "R7 drained", rx_pend, 0);

      // R2/R7 slower divisor, first-in first-out
      div_val = 12'd2;
      tx(9'h0A5, 8, 1'b1, 48);
      tx(9'h03C, 8, 1'b1, 48);
      read_top(8'hA5, 0, 0, "R7 order first");
      read_top(8'h3C, 0, 0, "R7 order second");

      // R3 nine-bit mode
      nine_en = 1'b1;
      for (int k = 0; k < 16; k++) begin
         logic [8:0] w;
         w = {k[0] ^ k[2], 8'((k * 37 + 11) % 256)};
         tx(w, 9, 1'b1, 48);
         read_top(w[7:0], w[8], 0, "R3 ninth bit");
      end

      // R4 address filter
      addr_en = 1'b1;
      tx(9'h055, 9, 1'b1, 48);
      @(negedge clk);
      chk(rx_pend == 1'b0, "R4 dropped data char", rx_pend, 0);
      tx(9'h1A7, 9, 1'b1, 48);
      read_top(8'hA7, 1, 0, "R4 address char");
      addr_en = 1'b0; nine_en = 1'b0;

      // R5/R6 per-slot stop error
      div_val = 12'd0;
      tx(9'h011, 8, 1'b0, 16);
      tx(9'h022, 8, 1'b1, 16);
      read_top(8'h11, 0, 1, "R5 error slot");
      read_top(8'h22, 0, 0, "R6 next char received clean");

      // R8/R9 overrun
      tx(9'h031, 8, 1'b1, 16);
      tx(9'h032, 8, 1'b1, 16);
      tx(9'h033, 8, 1'b1, 16);
      @(negedge clk);
      chk(ovr_err == 1'b1, "R8 overrun set", ovr_err, 1);
      read_top(8'h31, 0, 0, "R8 stored first");
      tx(9'h034, 8, 1'b1, 16);
      chk(ovr_err == 1'b1, "R9 overrun held", ovr_err, 1);
      read_top(8'h32, 0, 0, "R9 stored second");
      @(negedge clk);
      chk(rx_pend == 1'b0, "R9 frozen while overrun", rx_pend, 0);
      @(negedge clk) cont_en = 1'b0;
      @(negedge clk) cont_en = 1'b1;
      @(negedge clk);
      chk(ovr_err == 1'b0, "R9 cleared by cont_en", ovr_err, 0);
      tx(9'h035, 8, 1'b1, 16);
      read_top(8'h35, 0, 0, "R9 receiving again");

      // R9 cont_en keeps status, R1 port_en clears it
      tx(9'h044, 8, 1'b0, 16);
      @(negedge clk) cont_en = 1'b0;
      repeat (2) @(negedge clk);
      chk(rd_ferr == 1'b1 && rd_data == 8'h44, "R9 status kept", {rd_ferr, rd_data}, 9'h144);
      cont_en = 1'b1;
      @(negedge clk) port_en = 1'b0;
      @(negedge clk);
      chk({rx_pend, rd_ferr, rd_data} == 10'h0, "R1 port clear", {rx_pend, rd_ferr, rd_data}, 0);
      port_en = 1'b1;

      // R10 short low pulse
      div_val = 12'd2;
      @(negedge clk) rx_in = 1'b0;
      repeat (5) @(negedge clk);
      rx_in = 1'b1;
      repeat (900) @(negedge clk);
      chk(rx_pend == 1'b0, "R10 glitch rejected", rx_pend, 0);
      tx(9'h06E, 8, 1'b1, 48);
      read_top(8'h6E, 0, 0, "R10 next frame");

      // R12 same-cycle pop and completion
      div_val = 12'd0;
      port_cycle();
      send(9'h05C, 8, 1'b1, 16, -1, p);
      chk(p > 0, "R12 calibration", p, 1);
      read_top(8'h5C, 0, 0, "R12 calibration char");
      port_cycle();
      tx(9'h0A1, 8, 1'b1, 16);
      tx(9'h0B2, 8, 1'b1, 16);
      send(9'h0C3, 8, 1'b1, 16, p - 1, pa);
      @(negedge clk);
      chk(ovr_err == 1'b0, "R12 tie no overrun", ovr_err, 0);
      read_top(8'hB2, 0, 0, "R12 tie second");
      read_top(8'hC3, 0, 0, "R12 tie third stored");
      port_cycle();
      tx(9'h0A1, 8, 1'b1, 16);
      tx(9'h0B2, 8, 1'b1, 16);
      send(9'h0C3, 8, 1'b1, 16, p, pa);
      @(negedge clk);
      chk(ovr_err == 1'b1, "R12 late pop overruns", ovr_err, 1);
      read_top(8'hB2, 0, 0, "R12 late second");
      @(negedge clk);
      chk(rx_pend == 1'b0, "R12 late third lost", rx_pend, 0);

      done_f = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done_f) begin
         checks++;
         errs++;
         $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errs);
         $finish;
      end
   end

endmodule